// File: doc/BRIEF.md
# Compressed Floating-Point Load/Store Unit

This block takes one 16-bit compressed instruction at a time and carries it out if it is a floating-point load or store. It handles single- and double-precision accesses in two forms. The register-based form names a base register and a data register through 3-bit fields. The stack-relative form always uses integer register x2 as the base and names the data register with a full 5-bit field. The unit puts the scaled unsigned offset back together from the scattered immediate bits. It reads the base through a combinational integer-register read port and adds the offset to form a 32-bit address.

It then issues one memory request over a valid/ready handshake. For a load, it waits for the read response and writes the result into an internal 64-bit floating-point register file. A single-precision result is NaN-boxed before the write, and the write is also shown on a registered writeback port. For a store, it sends the floating-point register's contents as write data. Any other encoding is refused: the unit raises a one-cycle flag and makes no request.

Top module: `cfls_unit`

## Requirements
- R1: After synchronous reset, `busy`, `unsup`, `mem_req_valid` and `wb_valid` are all 0.
- R2: Register-based double forms are selected by bits[1:0]=00 with bits[15:13]=001 (load) or 101 (store). The offset is bits[12:10] as offset[5:3] and bits[6:5] as offset[7:6]. The base is x(8+bits[9:7]), the data register is f(8+bits[4:2]), and the address is base plus the zero-extended offset.
- R3: Stack-relative double forms are selected by bits[1:0]=10 and use x2 as the base. The load (001) takes offset[5] from bit 12, offset[4:3] from bits[6:5] and offset[8:6] from bits[4:2], with the register in bits[11:7]. The store (101) takes offset[5:3] from bits[12:10] and offset[8:6] from bits[9:7], with the register in bits[6:2].
- R4: Single forms use funct3 011 (load) and 111 (store). In the register-based layout, offset[5:3] comes from bits[12:10], offset[2] from bit 6 and offset[6] from bit 5. The stack-relative load takes offset[5] from bit 12, offset[4:2] from bits[6:4] and offset[7:6] from bits[3:2]. The stack-relative store takes offset[5:2] from bits[12:9] and offset[7:6] from bits[8:7]. `mem_req_dbl` is 0 for single forms and 1 for double forms.
- R5: A single load writes {32 ones, response[31:0]}. A double load writes the 64-bit response unchanged.
- R6: A single store drives the register's low 32 bits with the upper 32 bits zero. A double store drives all 64 bits.
- R7: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays valid and its address, write enable, size and write data do not change.
- R8: Any other encoding pulses `unsup` for one cycle after acceptance. It issues no request and leaves `busy` low.
- R9: `busy` rises the cycle after a legal instruction is accepted and falls once the access completes. `in_valid` is ignored while `busy` is high.
- R10: The register file is written on the clock edge where `mem_rsp_valid` is high. In the next cycle, `wb_valid` pulses with the register index and the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction offered |
| in_instr | input | 16 | Compressed instruction |
| busy | output | 1 | Access in flight; new instructions not taken |
| unsup | output | 1 | One-cycle pulse for an unsupported encoding |
| base_idx | output | 5 | Integer register index to read |
| base_val | input | XLEN | Value of integer register `base_idx` |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_addr | output | XLEN | Effective byte address |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_dbl | output | 1 | 1 = 8-byte access, 0 = 4-byte access |
| mem_req_wdata | output | FLEN | Store data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_rdata | input | FLEN | Read data |
| wb_valid | output | 1 | Register-file write happened last cycle |
| wb_idx | output | 5 | Register written |
| wb_data | output | FLEN | Value written |

## Verification
A table runs all eight load/store forms. Each form uses offsets whose set bits land in different scattered fields, including the largest and zero offsets, so a swapped or shifted bit field shows up as a wrong address. Single loads with data whose upper half is not all ones separate NaN boxing from a plain copy. Later stores of those same registers separate a truncated 32-bit store from a full 64-bit one, including a double store of a boxed value. Stall lengths of zero to three cycles test request holding. Separate directed tests drive several illegal encodings and offer instructions while the unit is busy.

// File: rtl/cfls_pkg.sv
package cfls_pkg;
  typedef struct packed {
    logic       legal;
    logic       is_store;
    logic       is_dbl;
    logic [4:0] base;
    logic [4:0] freg;
    logic [8:0] off;
  } cfls_dec_t;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} cfls_state_e;

  localparam logic [1:0] QUAD_REG = 2'b00;
  localparam logic [1:0] QUAD_SP  = 2'b10;
  localparam logic [2:0] F3_LD_D  = 3'b001;
  localparam logic [2:0] F3_ST_D  = 3'b101;
  localparam logic [2:0] F3_LD_W  = 3'b011;
  localparam logic [2:0] F3_ST_W  = 3'b111;
  localparam logic [4:0] SP_REG   = 5'd2;
endpackage

// File: rtl/cfls_decode.sv
module cfls_decode
  import cfls_pkg::*;
(
  input  logic [15:0] instr,
  output cfls_dec_t   dec
);
  logic [4:0] reg_base;
  logic [4:0] reg_data;

  assign reg_base = {2'b01, instr[9:7]};
  assign reg_data = {2'b01, instr[4:2]};

  always_comb begin
    dec = '0;
    case ({instr[15:13], instr[1:0]})
      {F3_LD_D, QUAD_REG}, {F3_ST_D, QUAD_REG}: begin
        dec.legal    = 1'b1;
        dec.is_store = instr[15];
        dec.is_dbl   = 1'b1;
        dec.base     = reg_base;
        dec.freg     = reg_data;
        dec.off      = {1'b0, instr[6:5], instr[12:10], 3'b000};
      end
      {F3_LD_W, QUAD_REG}, {F3_ST_W, QUAD_REG}: begin
        dec.legal    = 1'b1;
        dec.is_store = instr[15];
        dec.base     = reg_base;
        dec.freg     = reg_data;
        dec.off      = {2'b00, instr[5], instr[12:10], instr[6], 2'b00};
      end
      {F3_LD_D, QUAD_SP}: begin
        dec.legal  = 1'b1;
        dec.is_dbl = 1'b1;
        dec.base   = SP_REG;
        dec.freg   = instr[11:7];
        dec.off    = {instr[4:2], instr[12], instr[6:5], 3'b000};
      end
      {F3_ST_D, QUAD_SP}: begin
        dec.legal    = 1'b1;
        dec.is_store = 1'b1;
        dec.is_dbl   = 1'b1;
        dec.base     = SP_REG;
        dec.freg     = instr[6:2];
        dec.off      = {instr[9:7], instr[12:10], 3'b000};
      end
      {F3_LD_W, QUAD_SP}: begin
        dec.legal = 1'b1;
        dec.base  = SP_REG;
        dec.freg  = instr[11:7];
        dec.off   = {1'b0, instr[3:2], instr[12], instr[6:4], 2'b00};
      end
      {F3_ST_W, QUAD_SP}: begin
        dec.legal    = 1'b1;
        dec.is_store = 1'b1;
        dec.base     = SP_REG;
        dec.freg     = instr[6:2];
        dec.off      = {1'b0, instr[8:7], instr[12:9], 2'b00};
      end
      default: dec = '0;
    endcase
  end
endmodule

// File: rtl/cfls_fpr.sv
module cfls_fpr #(
  parameter int WIDTH = 64,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/cfls_unit.sv
module cfls_unit
  import cfls_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int FLEN = 64,
  localparam int WORD = 32,
  localparam int NREG = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [15:0]     in_instr,
  output logic            busy,
  output logic            unsup,
  output logic [4:0]      base_idx,
  input  logic [XLEN-1:0] base_val,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic [XLEN-1:0] mem_req_addr,
  output logic            mem_req_we,
  output logic            mem_req_dbl,
  output logic [FLEN-1:0] mem_req_wdata,
  input  logic            mem_rsp_valid,
  input  logic [FLEN-1:0] mem_rsp_rdata,
  output logic            wb_valid,
  output logic [4:0]      wb_idx,
  output logic [FLEN-1:0] wb_data
);
  cfls_dec_t   dec;
  cfls_state_e state;
  logic        accept, take;
  logic [4:0]  freg_q;
  logic        wb_dbl_q;
  logic [FLEN-1:0] st_q, ld_dbl, ld_val;
  logic        rf_we;

  cfls_decode u_dec (.instr(in_instr), .dec(dec));

  assign base_idx = dec.base;
  assign accept   = in_valid && (state == S_IDLE);
  assign take     = accept && dec.legal;
  assign busy     = (state != S_IDLE);
  assign mem_req_valid = (state == S_REQ);
  assign mem_req_wdata = mem_req_dbl ? st_q : {{(FLEN-WORD){1'b0}}, st_q[WORD-1:0]};

  generate
    if (FLEN > 64) begin : g_wide
      assign ld_dbl = {{(FLEN-64){1'b1}}, mem_rsp_rdata[63:0]};
    end else begin : g_exact
      assign ld_dbl = mem_rsp_rdata;
    end
  endgenerate

  assign ld_val = mem_req_dbl ? ld_dbl : {{(FLEN-WORD){1'b1}}, mem_rsp_rdata[WORD-1:0]};
  assign rf_we  = (state == S_WAIT) && mem_rsp_valid;

  cfls_fpr #(.WIDTH(FLEN), .DEPTH(NREG)) u_fpr (
    .clk  (clk),
    .we   (rf_we),
    .waddr(freg_q),
    .wdata(ld_val),
    .re   (take && dec.is_store),
    .raddr(dec.freg),
    .rdata(st_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= S_IDLE;
      unsup        <= 1'b0;
      wb_valid     <= 1'b0;
      wb_idx       <= '0;
      wb_data      <= '0;
      wb_dbl_q     <= 1'b0;
      freg_q       <= '0;
      mem_req_addr <= '0;
      mem_req_we   <= 1'b0;
      mem_req_dbl  <= 1'b0;
    end else begin
      unsup    <= accept && !dec.legal;
      wb_valid <= 1'b0;
      case (state)
        S_IDLE: if (take) begin
          mem_req_addr <= base_val + {{(XLEN-9){1'b0}}, dec.off};
          mem_req_we   <= dec.is_store;
          mem_req_dbl  <= dec.is_dbl;
          freg_q       <= dec.freg;
          state        <= S_REQ;
        end
        S_REQ: if (mem_req_ready) state <= mem_req_we ? S_IDLE : S_WAIT;
        S_WAIT: if (mem_rsp_valid) begin
          wb_valid <= 1'b1;
          wb_idx   <= freg_q;
          wb_data  <= ld_val;
          wb_dbl_q <= mem_req_dbl;
          state    <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) &&
    $stable(mem_req_we) && $stable(mem_req_dbl) && $stable(mem_req_wdata)); // R7
  AST_UNSUP_QUIET: assert property (@(posedge clk) disable iff (rst)
    unsup |-> !busy && !mem_req_valid); // R8
  AST_BOX_UPPER: assert property (@(posedge clk) disable iff (rst)
    wb_valid && !wb_dbl_q |-> &wb_data[FLEN-1:WORD]); // R5
  AST_WB_AFTER_RSP: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> $past(mem_rsp_valid) && !busy); // R10
  AST_BUSY_FROM_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(in_valid)); // R9
endmodule

// File: tb/cfls_unit_tb.sv
`timescale 1ns/1ps
module cfls_unit_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [15:0] in_instr = '0;
  logic busy, unsup;
  logic [4:0] base_idx;
  logic [31:0] base_val;
  logic mem_req_valid, mem_req_we, mem_req_dbl;
  logic mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic [63:0] mem_req_wdata;
  logic mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_rdata = '0;
  logic wb_valid;
  logic [4:0] wb_idx;
  logic [63:0] wb_data;

  int checks = 0;
  int errors = 0;
  logic [63:0] shadow [32];

  always #10 clk = ~clk;

  function automatic logic [31:0] xval(input logic [4:0] idx);
    return 32'h4000_0000 + 32'(idx) * 32'h0000_1010;
  endfunction
  assign base_val = xval(base_idx);

  cfls_unit u_dut (.*);

  task automatic check(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] enc(input logic [2:0] k, input logic [2:0] b,
                                      input logic [4:0] r, input logic [8:0] o);
    case (k)
      3'd0: return {3'b001, o[5:3], b, o[7:6], r[2:0], 2'b00};
      3'd1: return {3'b101, o[5:3], b, o[7:6], r[2:0], 2'b00};
      3'd2: return {3'b011, o[5:3], b, o[2], o[6], r[2:0], 2'b00};
      3'd3: return {3'b111, o[5:3], b, o[2], o[6], r[2:0], 2'b00};
      3'd4: return {3'b001, o[5], r, o[4:3], o[8:6], 2'b10};
      3'd5: return {3'b101, o[5:3], o[8:6], r, 2'b10};
      3'd6: return {3'b011, o[5], r, o[4:2], o[7:6], 2'b10};
      default: return {3'b111, o[5:2], o[7:6], r, 2'b10};
    endcase
  endfunction

  // kind: 0 FLD 1 FSD 2 FLW 3 FSW 4 FLDSP 5 FSDSP 6 FLWSP 7 FSWSP
  localparam logic [85:0] VEC [0:11] = '{
    {3'd0, 3'd2, 5'd9,  9'd200, 2'd0, 64'h0123456789ABCDEF},
    {3'd2, 3'd5, 5'd12, 9'd68,  2'd1, 64'hDEADBEEFCAFEF00D},
    {3'd4, 3'd0, 5'd3,  9'd488, 2'd0, 64'h1122334455667788},
    {3'd6, 3'd0, 5'd20, 9'd252, 2'd2, 64'h0000000087654321},
    {3'd0, 3'd0, 5'd15, 9'd0,   2'd0, 64'hFFFF0000FFFF0000},
    {3'd1, 3'd7, 5'd9,  9'd248, 2'd2, 64'h0},
    {3'd3, 3'd1, 5'd12, 9'd124, 2'd0, 64'h0},
    {3'd5, 3'd0, 5'd3,  9'd504, 2'd1, 64'h0},
    {3'd7, 3'd0, 5'd20, 9'd4,   2'd0, 64'h0},
    {3'd1, 3'd3, 5'd15, 9'd16,  2'd3, 64'h0},
    {3'd5, 3'd0, 5'd12, 9'd0,   2'd0, 64'h0},
    {3'd3, 3'd4, 5'd9,  9'd64,  2'd0, 64'h0}
  };

  task automatic run_one(input logic [2:0] k, input logic [2:0] bf, input logic [4:0] fr,
                         input logic [8:0] off, input int stall, input logic [63:0] data);
    logic dbl, st, sp;
    logic [31:0] ea, a0;
    logic [63:0] expw, expl, w0;
    string tg;
    dbl = (k == 3'd0) || (k == 3'd1) || (k == 3'd4) || (k == 3'd5);
    st  = k[0];
    sp  = k[2];
    tg  = !dbl ? "R4" : (sp ? "R3" : "R2");
    ea  = xval(sp ? 5'd2 : {2'b01, bf}) + {23'd0, off};
    @(negedge clk);
    in_valid = 1'b1;
    in_instr = enc(k, bf, fr, off);
    @(negedge clk);
    in_valid = 1'b0;
    check(busy === 1'b1, "R9 busy after accept", {63'd0, busy}, 64'd1);
    check(mem_req_valid === 1'b1, "R7 request valid", {63'd0, mem_req_valid}, 64'd1);
    check(mem_req_addr === ea, tg, {32'd0, mem_req_addr}, {32'd0, ea});
    check({mem_req_we, mem_req_dbl} === {st, dbl}, "R4 we/size", {62'd0, mem_req_we, mem_req_dbl}, {62'd0, st, dbl});
    if (st) begin
      expw = dbl ? shadow[fr] : {32'd0, shadow[fr][31:0]};
      check(mem_req_wdata === expw, "R6 store data", mem_req_wdata, expw);
    end
    a0 = mem_req_addr;
    w0 = mem_req_wdata;
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      check(mem_req_valid === 1'b1 && mem_req_addr === a0 && mem_req_wdata === w0,
            "R7 hold", {32'd0, mem_req_addr}, {32'd0, a0});
    end
    mem_req_ready = 1'b1;
    @(negedge clk);
    mem_req_ready = 1'b0;
    if (!st) begin
      check(wb_valid === 1'b0 && mem_req_valid === 1'b0, "R10 no early writeback", {63'd0, wb_valid}, 64'd0);
      mem_rsp_valid = 1'b1;
      mem_rsp_rdata = data;
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      expl = dbl ? data : {32'hFFFF_FFFF, data[31:0]};
      check(wb_valid === 1'b1 && wb_idx === fr, "R10 writeback strobe", {58'd0, wb_valid, wb_idx}, {58'd0, 1'b1, fr});
      check(wb_data === expl, "R5 load value", wb_data, expl);
      shadow[fr] = expl;
    end
    check(busy === 1'b0, "R9 busy clears", {63'd0, busy}, 64'd0);
  endtask

  task automatic try_illegal(input logic [15:0] ins);
    @(negedge clk);
    in_valid = 1'b1;
    in_instr = ins;
    @(negedge clk);
    in_valid = 1'b0;
    check(unsup === 1'b1 && busy === 1'b0 && mem_req_valid === 1'b0, "R8 unsupported",
          {61'd0, unsup, busy, mem_req_valid}, 64'd4);
    @(negedge clk);
    check(unsup === 1'b0 && mem_req_valid === 1'b0, "R8 single pulse", {62'd0, unsup, mem_req_valid}, 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) shadow[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(busy === 1'b0 && unsup === 1'b0 && mem_req_valid === 1'b0 && wb_valid === 1'b0,
          "R1 reset state", {60'd0, busy, unsup, mem_req_valid, wb_valid}, 64'd0);

    for (int v = 0; v < 12; v++)
      run_one(VEC[v][85:83], VEC[v][82:80], VEC[v][79:75], VEC[v][74:66], int'(VEC[v][65:64]), VEC[v][63:0]);

    try_illegal(16'h0001);
    try_illegal(16'h0000);
    try_illegal(16'h4082);
    try_illegal(16'hA007);

    // R9: offers during an in-flight access are ignored
    @(negedge clk);
    in_valid = 1'b1;
    in_instr = enc(3'd0, 3'd1, 5'd10, 9'd40);
    @(negedge clk);
    in_instr = enc(3'd5, 3'd0, 5'd3, 9'd8);
    repeat (3) begin
      @(negedge clk);
      check(mem_req_addr === xval(5'd9) + 32'd40 && mem_req_we === 1'b0, "R9 offer ignored",
            {32'd0, mem_req_addr}, {32'd0, xval(5'd9) + 32'd40});
    end
    in_valid = 1'b0;
    mem_req_ready = 1'b1;
    @(negedge clk);
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b1;
    mem_rsp_rdata = 64'h5555AAAA5555AAAA;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    check(wb_idx === 5'd10 && wb_data === 64'h5555AAAA5555AAAA, "R5 double unchanged", wb_data, 64'h5555AAAA5555AAAA);
    repeat (3) begin
      @(negedge clk);
      check(mem_req_valid === 1'b0 && busy === 1'b0, "R9 no late request", {62'd0, mem_req_valid, busy}, 64'd0);
    end

    // R1: reset during an access returns to idle
    @(negedge clk);
    in_valid = 1'b1;
    in_instr = enc(3'd2, 3'd0, 5'd8, 9'd4);
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(busy === 1'b0 && mem_req_valid === 1'b0, "R1 reset mid access", {62'd0, busy, mem_req_valid}, 64'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule